// File: doc/BRIEF.md
# PWM Output Fault Conditioning Stage

This block sits between four PWM generators and the device pins. Each generator delivers two already-shaped PWM signals, so eight signals in all. For every signal the block can replace the level with a programmed safe value while its generator is in a fault. It can then invert the result, and it can block the signal from the pin entirely.

Each generator computes its own fault condition from three sources, each of which can be enabled on its own:
- an external fault pin, with a selectable active level and a programmable persistence filter;
- a debug-stall request shared by all generators;
- a per-generator comparator trigger.

A recognised fault sets a sticky status bit for that generator. Forcing stays active for as long as the bit is set. Software clears the bit by writing one to it, which appears here as a one-cycle clear pulse.

Top module: `pwm_out_cond`

## Requirements
- R1: When `out_en[i]` is 0, `pin_out[i]` is 0 whatever the fault, inversion and input state.
- R2: When enabled, with `fault_stat[g]` set (g = i/2) and `fault_sel[i]` = 1, `pin_out[i]` equals `fault_val[i]` XOR `out_inv[i]`.
- R3: When enabled, with `fault_sel[i]` = 0, `pin_out[i]` follows `pwm_in[i]` XOR `out_inv[i]` even while `fault_stat[g]` is set.
- R4: When enabled and no fault is latched, `pin_out[i]` equals `pwm_in[i]` XOR `out_inv[i]`.
- R5: The fault pin of generator g is active when `fault_pin[g]` equals `fault_pol[g]`: 1 means active high, 0 means active low.
- R6: With `pin_en[g]` = 1 and filter length N taken from bits [4g+3:4g] of `filt_len`, `fault_stat[g]` sets after the rising edge at which the pin has been sampled active on N+2 consecutive edges. Any inactive sample restarts the count.
- R7: An enabled debug stall (`dbg_stall` with `stall_en[g]`) or an enabled comparator trigger (`cmp_trig[g]` with `cmp_en[g]`) sets `fault_stat[g]` at the first edge that samples it. A disabled source has no effect.
- R8: `fault_stat[g]` stays set until the edge that samples `fault_clr[g]` = 1 while no enabled source is active. If a source is active at that edge, the set wins.
- R9: Forcing follows `fault_stat[g]` in the same cycle. An enabled stall or trigger forces the outputs one edge after it is applied, and a filtered pin fault forces them one edge after the filter output rises.
- R10: Generator g affects only signals 2g and 2g+1.
- R11: While `rst_n` is 0, all fault status bits and filter state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 8 | Generated PWM signals, two per generator |
| fault_pin | input | 4 | External fault pin per generator |
| fault_pol | input | 4 | Active level of each fault pin |
| filt_len | input | 16 | Filter length N per generator, 4 bits each |
| pin_en | input | 4 | Fault-pin source enable per generator |
| dbg_stall | input | 1 | Debug stall request |
| stall_en | input | 4 | Stall source enable per generator |
| cmp_trig | input | 4 | Comparator trigger per generator |
| cmp_en | input | 4 | Comparator source enable per generator |
| fault_clr | input | 4 | Write-one-to-clear pulse per status bit |
| out_en | input | 8 | Output enable per signal |
| fault_sel | input | 8 | 1 = substitute the safe value during a fault |
| fault_val | input | 8 | Safe value per signal |
| out_inv | input | 8 | Final inversion per signal |
| pin_out | output | 8 | Conditioned pin signals |
| fault_stat | output | 4 | Latched fault status per generator |

## Verification
Two functions can act on the same status bit in the same cycle: the write-one-to-clear pulse and a fault source that is still active, whether the filtered pin or a stall. Directed cases hold a stall high while pulsing the clear, and random traffic issues frequent clears against frequently active sources. In both, the bench expects the set to win and keeps the forced pin values. Output substitution and inversion also change together on one signal, and every pin is compared each cycle with the expected value computed by the bench.

// File: rtl/pwm_cond_pkg.sv
package pwm_cond_pkg;
   // per-signal output configuration
   typedef struct packed {
      logic en;
      logic fsel;
      logic fval;
      logic inv;
   } lane_cfg_t;

   localparam int unsigned SIG_PER_GEN = 2;
endpackage

// File: rtl/pwm_fault_filter.sv
module pwm_fault_filter #(
   parameter int unsigned FILT_W     = 4,
   parameter bit          HAS_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin,
   input  logic              pol,
   input  logic [FILT_W-1:0] len,
   output logic              filt
);
   logic active;
   assign active = (pin == pol);

   generate
      if (HAS_FILTER) begin : g_filt
         logic [FILT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt  <= '0;
               filt <= 1'b0;
            end else if (!active) begin
               cnt  <= '0;
               filt <= 1'b0;
            end else if (cnt >= len) begin
               filt <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) filt <= 1'b0;
            else        filt <= active;
         end
      end
   endgenerate

   // R6: a recognised fault implies the level was active at the last edge
   a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_n)
      filt |-> $past(pin == pol));
endmodule

// File: rtl/pwm_fault_latch.sv
module pwm_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic filt,
   input  logic pin_en,
   input  logic stall,
   input  logic stall_en,
   input  logic trig,
   input  logic trig_en,
   input  logic clr,
   output logic stat
);
   logic raw;
   assign raw = (filt & pin_en) | (stall & stall_en) | (trig & trig_en);

   always_ff @(posedge clk) begin
      if (!rst_n) stat <= 1'b0;
      else        stat <= (stat & ~clr) | raw;
   end

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !clr) |=> stat);
   a_r7_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && stall_en) |=> stat);
   a_r7_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && trig_en) |=> stat);
endmodule

// File: rtl/pwm_out_lane.sv
module pwm_out_lane
   import pwm_cond_pkg::*;
(
   input  lane_cfg_t cfg,
   input  logic      pwm,
   input  logic      fault,
   output logic      pin
);
   logic subst;
   always_comb begin
      subst = (fault && cfg.fsel) ? cfg.fval : pwm;
      pin   = cfg.en ? (subst ^ cfg.inv) : 1'b0;
   end
endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond
   import pwm_cond_pkg::*;
#(
   parameter int unsigned NUM_GEN    = 4,
   parameter int unsigned FILT_W     = 4,
   parameter bit          HAS_FILTER = 1'b1,
   localparam int unsigned NUM_SIG   = NUM_GEN * SIG_PER_GEN
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SIG-1:0]        pwm_in,
   input  logic [NUM_GEN-1:0]        fault_pin,
   input  logic [NUM_GEN-1:0]        fault_pol,
   input  logic [NUM_GEN*FILT_W-1:0] filt_len,
   input  logic [NUM_GEN-1:0]        pin_en,
   input  logic                      dbg_stall,
   input  logic [NUM_GEN-1:0]        stall_en,
   input  logic [NUM_GEN-1:0]        cmp_trig,
   input  logic [NUM_GEN-1:0]        cmp_en,
   input  logic [NUM_GEN-1:0]        fault_clr,
   input  logic [NUM_SIG-1:0]        out_en,
   input  logic [NUM_SIG-1:0]        fault_sel,
   input  logic [NUM_SIG-1:0]        fault_val,
   input  logic [NUM_SIG-1:0]        out_inv,
   output logic [NUM_SIG-1:0]        pin_out,
   output logic [NUM_GEN-1:0]        fault_stat
);
   generate
      if (NUM_GEN < 1)  begin : g_bad_gen  $error("NUM_GEN must be at least 1");  end
      if (FILT_W < 1)   begin : g_bad_filt $error("FILT_W must be at least 1");   end
   endgenerate

   logic [NUM_GEN-1:0] filt;

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      pwm_fault_filter #(.FILT_W(FILT_W), .HAS_FILTER(HAS_FILTER)) u_filt (
         .clk (clk),
         .rst_n (rst_n),
         .pin (fault_pin[g]),
         .pol (fault_pol[g]),
         .len (filt_len[g*FILT_W +: FILT_W]),
         .filt (filt[g])
      );
      pwm_fault_latch u_latch (
         .clk (clk),
         .rst_n (rst_n),
         .filt (filt[g]),
         .pin_en (pin_en[g]),
         .stall (dbg_stall),
         .stall_en (stall_en[g]),
         .trig (cmp_trig[g]),
         .trig_en (cmp_en[g]),
         .clr (fault_clr[g]),
         .stat (fault_stat[g])
      );
      // R9: filtered pin fault forces outputs one edge later
      a_r9_pin_to_stat: assert property (@(posedge clk) disable iff (!rst_n)
         (filt[g] && pin_en[g]) |=> fault_stat[g]);
   end

   for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
      lane_cfg_t cfg;
      assign cfg = '{en: out_en[i], fsel: fault_sel[i], fval: fault_val[i], inv: out_inv[i]};
      pwm_out_lane u_lane (
         .cfg (cfg),
         .pwm (pwm_in[i]),
         .fault (fault_stat[i/SIG_PER_GEN]),
         .pin (pin_out[i])
      );
      a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
         !out_en[i] |-> !pin_out[i]);
      a_r2_safe_value: assert property (@(posedge clk) disable iff (!rst_n)
         (out_en[i] && fault_sel[i] && fault_stat[i/SIG_PER_GEN])
            |-> (pin_out[i] == (fault_val[i] ^ out_inv[i])));
   end
endmodule

// File: tb/tb_pwm_out_cond.sv
module tb_pwm_out_cond;
   localparam int NG = 4;
   localparam int NS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS-1:0] pwm_in = '0, out_en = '0, fault_sel = '0, fault_val = '0, out_inv = '0;
   logic [NG-1:0] fault_pin = '0, fault_pol = '1, pin_en = '0, stall_en = '0;
   logic [NG-1:0] cmp_trig = '0, cmp_en = '0, fault_clr = '0;
   logic [NG*4-1:0] filt_len = '0;
   logic dbg_stall = 1'b0;
   logic [NS-1:0] pin_out;
   logic [NG-1:0] fault_stat;

   int errors = 0, checks = 0;
   int m_cnt [NG];
   bit m_filt [NG];
   bit m_stat [NG];
   bit done = 0;

   always #2.5 clk = ~clk;

   pwm_out_cond dut (.*);

   // reference model of the requirements
   always @(posedge clk) begin
      for (int g = 0; g < NG; g++) begin
         bit act, raw;
         if (!rst_n) begin
            m_cnt[g] = 0; m_filt[g] = 0; m_stat[g] = 0;            // R11
         end else begin
            raw = (m_filt[g] && pin_en[g]) || (dbg_stall && stall_en[g]) ||
                  (cmp_trig[g] && cmp_en[g]);
            m_stat[g] = (m_stat[g] && !fault_clr[g]) || raw;        // R7 R8
            act = (fault_pin[g] == fault_pol[g]);                   // R5
            if (!act) begin m_cnt[g] = 0; m_filt[g] = 0; end
            else if (m_cnt[g] >= int'(filt_len[g*4 +: 4])) m_filt[g] = 1; // R6
            else m_cnt[g]++;
         end
      end
   end

   function automatic bit exp_pin(int i);
      bit v;
      if (!out_en[i]) return 1'b0;                                  // R1
      v = (m_stat[i/2] && fault_sel[i]) ? fault_val[i] : pwm_in[i]; // R2 R3 R4 R10
      return v ^ out_inv[i];
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      for (int i = 0; i < NS; i++) chk("R1/R2/R3/R4 pin", pin_out[i], exp_pin(i));
      for (int g = 0; g < NG; g++) chk("R6/R7/R8 stat", fault_stat[g], m_stat[g]);
   endtask

   // advance one edge, then compare away from the edge
   task automatic cyc();
      @(posedge clk);
      #1;
      check_all();
   endtask

   task automatic clear_all();
      fault_clr = '1;
      cyc();
      fault_clr = '0;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      repeat (3) cyc();
      chk("R11 reset stat", fault_stat, 0);
      chk("R11 reset pins", pin_out, 0);
      rst_n = 1'b1;
      out_en = '1; fault_sel = '1; fault_val = 8'hA5; pwm_in = 8'h3C;
      cyc();
      chk("R4 pass-through", pin_out, 8'h3C);
      out_inv = 8'h0F; #1;
      chk("R4 inversion", pin_out, 8'h33);

      // R6: N=3 on generator 0, status after the 5th edge
      out_inv = '0; fault_pol = 4'b1111; pin_en = 4'b0001; filt_len = 16'h0003;
      fault_pin[0] = 1'b1;
      for (int k = 0; k < 4; k++) begin cyc(); chk("R6 not yet", fault_stat[0], 0); end
      cyc();
      chk("R6 recognised", fault_stat[0], 1);
      chk("R2 gen0 forced", pin_out[1:0], 2'b01);
      chk("R10 others untouched", pin_out[7:2], 6'b001111);
      fault_pin[0] = 1'b0;
      repeat (2) cyc();
      chk("R8 still latched", fault_stat[0], 1);
      clear_all(); cyc();
      chk("R8 cleared", fault_stat[0], 0);

      // R6 glitch restarts count: N=2, active 2, gap, active 2
      filt_len = 16'h0002; fault_pin[0] = 1'b1; repeat (2) cyc();
      fault_pin[0] = 1'b0; cyc();
      fault_pin[0] = 1'b1; repeat (2) cyc();
      chk("R6 glitch restart", fault_stat[0], 0);
      fault_pin[0] = 1'b0; cyc();

      // R5 active low, N=0 -> two edges
      fault_pol[1] = 1'b0; pin_en = 4'b0010; filt_len = 16'h0000; fault_pin[1] = 1'b0;
      cyc(); chk("R5 one edge", fault_stat[1], 0);
      cyc(); chk("R5 active low", fault_stat[1], 1);
      fault_pin[1] = 1'b1; fault_pol[1] = 1'b1; pin_en = '0; cyc(); clear_all(); cyc();

      // R7 disabled stall ignored, enabled stall sets in one edge; R8 set beats clear
      dbg_stall = 1'b1; cyc();
      chk("R7 disabled stall", fault_stat, 0);
      stall_en = 4'b0100; cyc();
      chk("R7 stall", fault_stat, 4'b0100);
      chk("R9 forced same cycle", pin_out[5:4], 2'b10);
      fault_clr = 4'b0100; cyc();
      chk("R8 set wins", fault_stat[2], 1);
      dbg_stall = 1'b0; cyc(); fault_clr = '0;
      chk("R8 clear", fault_stat[2], 0);
      stall_en = '0;

      // R7 comparator trigger, R3 ignore-fault lane, R1 disabled with inversion
      cmp_en = 4'b1000; cmp_trig = 4'b1000; cyc(); cmp_trig = '0;
      chk("R7 cmp", fault_stat[3], 1);
      fault_sel[7] = 1'b0; out_en[6] = 1'b0; out_inv[7:6] = 2'b11; pwm_in[7:6] = 2'b10; #1;
      chk("R3 keep generated", pin_out[7], 0);
      chk("R1 disabled low", pin_out[6], 0);
      clear_all(); cmp_en = '0;

      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         pwm_in = $urandom;
         if ($urandom_range(0, 15) == 0) begin
            out_en = $urandom; fault_sel = $urandom; fault_val = $urandom; out_inv = $urandom;
            fault_pol = $urandom; pin_en = $urandom; stall_en = $urandom; cmp_en = $urandom;
            for (int g = 0; g < NG; g++) filt_len[g*4 +: 4] = 4'($urandom_range(0, 3));
         end
         for (int g = 0; g < NG; g++)
            if ($urandom_range(0, 5) == 0) fault_pin[g] = ~fault_pin[g];
         dbg_stall = ($urandom_range(0, 31) == 0);
         for (int g = 0; g < NG; g++) cmp_trig[g] = ($urandom_range(0, 15) == 0);
         fault_clr = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0;
         cyc();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule